// File: doc/BRIEF.md
# Dual-Port Software-Refilled Translation Buffer

This block is a small, fully associative address translation buffer for the data side of a processor's memory management. It holds sixteen entries. Each entry carries a virtual page number, an 8-bit task tag, a global flag, a 3-bit page-size code, a physical page number and three protection flags: write allowed, execute allowed, and privileged-only. Page size is chosen per entry, from 4 KB up to 16 MB in steps of four. The virtual page bits below the chosen size are left out of the compare and are passed straight through to the physical address.

Two lookup ports are served in the same clock. Each port presents a 32-bit virtual address, the task tag of the running task, and the kind of access: write, execute, and whether the processor is in privileged mode. One cycle later the port returns a hit flag, a fault cause and the physical address. A miss, a protection violation or an ambiguous match is reported as a fault cause, and the faulting address is captured per port for the exception handler. No hardware walks page tables. Software fills or invalidates an entry through a single write port, or clears every entry at once.

Top module: `tlb_dual`

## Requirements
- R1: Size code s (0 to 6) gives a page of 4 KB times 4 to the power s. The low 12+2s address bits take no part in the compare. Code 7 behaves as code 6.
- R2: An entry matches only when its task tag equals the lookup's tag, unless its global flag is set. A global entry matches any tag.
- R3: The response on a port (rs_valid, rs_hit, rs_cause, rs_pa) appears on the clock edge after the request. rs_valid follows lk_req. rs_hit is 1 exactly when one valid entry matches. When there is no request, rs_hit, rs_cause and rs_pa are 0.
- R4: When the cause is 0, rs_pa takes its page bits from the entry's physical page number and its offset bits (the low 12+2s bits) from the virtual address. When the cause is not 0, rs_pa is 0.
- R5: rs_cause encodes 0 none, 1 miss, 2 write violation, 3 execute violation, 4 privileged violation and 5 multiple match. The priority is 5, then 1, then 4, then 2, then 3.
- R6: A non-privileged access (lk_sup=0) to a privileged-only entry gives cause 4.
- R7: A write to an entry without write permission gives cause 2. An execute access to an entry without execute permission gives cause 3.
- R8: When two or more entries match, the result is cause 5 with rs_hit=0.
- R9: Each port captures its request address into rs_fault_va when its response has a non-zero cause. Otherwise rs_fault_va holds its value.
- R10: A software write replaces the whole entry in one edge. A lookup issued in the same cycle as the write sees the old contents. A lookup in the next cycle sees the new contents.
- R11: Writing with wr_valid=0 invalidates one entry. inv_all clears every entry, and it wins over a write in the same cycle.
- R12: The two ports work independently in the same cycle, each with its own address, tag and access kind.
- R13: After reset every entry is invalid, rs_valid is 0 and rs_fault_va is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_valid | input | 1 | Valid flag written (0 invalidates) |
| wr_global | input | 1 | Entry ignores task tag |
| wr_tid | input | 8 | Task tag written |
| wr_size | input | 3 | Page-size code written |
| wr_vpn | input | 20 | Virtual page number written |
| wr_ppn | input | 20 | Physical page number written |
| wr_wr_ok | input | 1 | Write permitted |
| wr_ex_ok | input | 1 | Execute permitted |
| wr_sup_only | input | 1 | Privileged-only entry |
| inv_all | input | 1 | Clear every entry |
| lk_req | input | 2 | Per-port lookup request |
| lk_va | input | 2x32 | Per-port virtual address |
| lk_tid | input | 2x8 | Per-port task tag |
| lk_wr | input | 2 | Per-port write access |
| lk_ex | input | 2 | Per-port execute access |
| lk_sup | input | 2 | Per-port privileged mode |
| rs_valid | output | 2 | Response present |
| rs_hit | output | 2 | Exactly one entry matched |
| rs_cause | output | 2x3 | Fault cause code |
| rs_pa | output | 2x32 | Translated physical address |
| rs_fault_va | output | 2x32 | Last faulting virtual address |

## Verification
The hardest case to reach is an ambiguous match. A correct refill handler never creates one, so it only appears when software deliberately writes two overlapping entries of different sizes, one of them global. The bench builds that overlap on purpose. It then probes an address inside both pages and an address inside only the larger page, and it repeats the probe with a foreign task tag so that only the global entry can answer. The ordering between a software write and a lookup in the same cycle is also driven directly, by raising the write strobe and the request on one clock edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W    = 32;
    localparam int TID_W   = 8;
    localparam int N_ENT   = 16;
    localparam int IDX_W   = $clog2(N_ENT);
    localparam int PG_LSB  = 12;
    localparam int PN_W    = VA_W - PG_LSB;
    localparam int SZ_W    = 3;
    localparam int MAX_SZ  = 6;
    localparam int N_PORT  = 2;
    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_MISS  = 3'd1,
        CAUSE_WRITE = 3'd2,
        CAUSE_EXEC  = 3'd3,
        CAUSE_SUPER = 3'd4,
        CAUSE_MULTI = 3'd5
    } cause_e;

    typedef struct packed {
        logic             valid;
        logic             global;
        logic [TID_W-1:0] tid;
        logic [SZ_W-1:0]  size;
        logic [PN_W-1:0]  vpn;
        logic [PN_W-1:0]  ppn;
        logic             wr_ok;
        logic             ex_ok;
        logic             sup_only;
    } entry_t;

    typedef struct packed {
        logic [VA_W-1:0]  va;
        logic [TID_W-1:0] tid;
        logic             is_wr;
        logic             is_ex;
        logic             is_sup;
    } req_t;

    typedef struct packed {
        logic            hit;
        cause_e          cause;
        logic [VA_W-1:0] pa;
    } resp_t;

    // Page-number bits that take part in the compare for a size code.
    function automatic logic [PN_W-1:0] size_mask(logic [SZ_W-1:0] sz);
        logic [SZ_W-1:0] s;
        logic [PN_W-1:0] m;
        s = (sz > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : sz;
        m = '1;
        for (int i = 0; i < 2 * MAX_SZ; i++) begin
            if (i < 2 * int'(s)) m[i] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_entry,
    input  logic             inv_all,
    output entry_t           ents [N_ENT]
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (rst) begin
                ents[i] <= '0;
            end else if (inv_all) begin
                ents[i].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ents[i] <= wr_entry;
            end
        end
    end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
(
    input  req_t   req,
    input  entry_t ents [N_ENT],
    output resp_t  resp
);

    logic [N_ENT-1:0] match;
    logic [PN_W-1:0]  va_pn;
    logic [PN_W-1:0]  sel_mask;
    entry_t           sel;

    assign va_pn = req.va[VA_W-1:PG_LSB];

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic [PN_W-1:0] m;
        logic            tag_ok;
        assign m        = size_mask(ents[g].size);
        assign tag_ok   = ents[g].global || (ents[g].tid == req.tid);
        assign match[g] = ents[g].valid && tag_ok &&
                          (((ents[g].vpn ^ va_pn) & m) == '0);
    end

    // OR-select of the matching entry; only meaningful on a single match.
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) sel = entry_t'(sel | ents[i]);
        end
    end

    assign sel_mask = size_mask(sel.size);

    always_comb begin
        resp = '0;
        if ($countones(match) > 1) begin
            resp.cause = CAUSE_MULTI;
        end else if (match == '0) begin
            resp.cause = CAUSE_MISS;
        end else begin
            resp.hit = 1'b1;
            if (sel.sup_only && !req.is_sup) begin
                resp.cause = CAUSE_SUPER;
            end else if (req.is_wr && !sel.wr_ok) begin
                resp.cause = CAUSE_WRITE;
            end else if (req.is_ex && !sel.ex_ok) begin
                resp.cause = CAUSE_EXEC;
            end else begin
                resp.cause = CAUSE_NONE;
                resp.pa    = {(sel.ppn & sel_mask) | (va_pn & ~sel_mask),
                              req.va[PG_LSB-1:0]};
            end
        end
    end

endmodule

// File: rtl/tlb_port_out.sv
module tlb_port_out
    import tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_vld,
    input  logic [VA_W-1:0] req_va,
    input  resp_t           comb,
    output resp_t           q,
    output logic            q_vld,
    output logic [VA_W-1:0] fault_va
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q_vld    <= 1'b0;
            fault_va <= '0;
        end else begin
            q_vld <= req_vld;
            q     <= req_vld ? comb : '0;
            if (req_vld && (comb.cause != CAUSE_NONE)) begin
                fault_va <= req_va;
            end
        end
    end

endmodule

// File: rtl/tlb_dual.sv
module tlb_dual
    import tlb_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic                            wr_valid,
    input  logic                            wr_global,
    input  logic [TID_W-1:0]                wr_tid,
    input  logic [SZ_W-1:0]                 wr_size,
    input  logic [PN_W-1:0]                 wr_vpn,
    input  logic [PN_W-1:0]                 wr_ppn,
    input  logic                            wr_wr_ok,
    input  logic                            wr_ex_ok,
    input  logic                            wr_sup_only,
    input  logic                            inv_all,
    input  logic [N_PORT-1:0]               lk_req,
    input  logic [N_PORT-1:0][VA_W-1:0]     lk_va,
    input  logic [N_PORT-1:0][TID_W-1:0]    lk_tid,
    input  logic [N_PORT-1:0]               lk_wr,
    input  logic [N_PORT-1:0]               lk_ex,
    input  logic [N_PORT-1:0]               lk_sup,
    output logic [N_PORT-1:0]               rs_valid,
    output logic [N_PORT-1:0]               rs_hit,
    output logic [N_PORT-1:0][CAUSE_W-1:0]  rs_cause,
    output logic [N_PORT-1:0][VA_W-1:0]     rs_pa,
    output logic [N_PORT-1:0][VA_W-1:0]     rs_fault_va
);

    entry_t wr_entry;
    entry_t ents [N_ENT];

    always_comb begin
        wr_entry.valid    = wr_valid;
        wr_entry.global   = wr_global;
        wr_entry.tid      = wr_tid;
        wr_entry.size     = wr_size;
        wr_entry.vpn      = wr_vpn;
        wr_entry.ppn      = wr_ppn;
        wr_entry.wr_ok    = wr_wr_ok;
        wr_entry.ex_ok    = wr_ex_ok;
        wr_entry.sup_only = wr_sup_only;
    end

    tlb_entry_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .inv_all  (inv_all),
        .ents     (ents)
    );

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        req_t  rq;
        resp_t rc;
        resp_t rr;

        always_comb begin
            rq.va     = lk_va[p];
            rq.tid    = lk_tid[p];
            rq.is_wr  = lk_wr[p];
            rq.is_ex  = lk_ex[p];
            rq.is_sup = lk_sup[p];
        end

        tlb_lookup u_look (
            .req  (rq),
            .ents (ents),
            .resp (rc)
        );

        tlb_port_out u_out (
            .clk      (clk),
            .rst      (rst),
            .req_vld  (lk_req[p]),
            .req_va   (lk_va[p]),
            .comb     (rc),
            .q        (rr),
            .q_vld    (rs_valid[p]),
            .fault_va (rs_fault_va[p])
        );

        assign rs_hit[p]   = rr.hit;
        assign rs_cause[p] = rr.cause;
        assign rs_pa[p]    = rr.pa;
    end

endmodule

// File: rtl/tlb_dual_chk.sv
module tlb_dual_chk
    import tlb_pkg::*;
(
    input logic                           clk,
    input logic                           rst,
    input logic                           inv_all,
    input logic [N_PORT-1:0]              lk_req,
    input logic [N_PORT-1:0][VA_W-1:0]    lk_va,
    input logic [N_PORT-1:0]              rs_valid,
    input logic [N_PORT-1:0]              rs_hit,
    input logic [N_PORT-1:0][CAUSE_W-1:0] rs_cause,
    input logic [N_PORT-1:0][VA_W-1:0]    rs_pa,
    input logic [N_PORT-1:0][VA_W-1:0]    rs_fault_va
);

    for (genvar p = 0; p < N_PORT; p++) begin : g_p
        // R3
        rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
            lk_req[p] |=> rs_valid[p]);
        // R3
        rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !lk_req[p] |=> (!rs_valid[p] && !rs_hit[p] && rs_cause[p] == '0 && rs_pa[p] == '0));
        // R3
        hit_cause_agree_chk: assert property (@(posedge clk) disable iff (rst)
            rs_valid[p] |-> (rs_hit[p] == (rs_cause[p] != 3'd1 && rs_cause[p] != 3'd5)));
        // R5
        cause_range_chk: assert property (@(posedge clk) disable iff (rst)
            rs_valid[p] |-> (rs_cause[p] <= 3'd5));
        // R4
        offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (rs_valid[p] && rs_cause[p] == '0) |-> (rs_pa[p][PG_LSB-1:0] == $past(lk_va[p][PG_LSB-1:0])));
        // R4
        fault_pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (rs_valid[p] && rs_cause[p] != '0) |-> (rs_pa[p] == '0));
        // R9
        fault_capture_chk: assert property (@(posedge clk) disable iff (rst)
            (rs_valid[p] && rs_cause[p] != '0) |-> (rs_fault_va[p] == $past(lk_va[p])));
        // R9
        fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!rs_valid[p] || rs_cause[p] == '0) |-> $stable(rs_fault_va[p]));
        // R11
        inv_all_miss_chk: assert property (@(posedge clk) disable iff (rst)
            inv_all ##1 lk_req[p] |=> (rs_cause[p] == 3'd1));
    end

endmodule

bind tlb_dual tlb_dual_chk chk_i (.*);

// File: tb/tlb_dual_tb_top.sv
module tlb_dual_tb_top;
    import tlb_pkg::*;

    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    logic              rst;
    logic              wr_en;
    logic [3:0]        wr_idx;
    logic              wr_valid, wr_global;
    logic [7:0]        wr_tid;
    logic [2:0]        wr_size;
    logic [19:0]       wr_vpn, wr_ppn;
    logic              wr_wr_ok, wr_ex_ok, wr_sup_only;
    logic              inv_all;
    logic [1:0]        lk_req;
    logic [1:0][31:0]  lk_va;
    logic [1:0][7:0]   lk_tid;
    logic [1:0]        lk_wr, lk_ex, lk_sup;
    logic [1:0]        rs_valid, rs_hit;
    logic [1:0][2:0]   rs_cause;
    logic [1:0][31:0]  rs_pa, rs_fault_va;

    tlb_dual dut_i (.*);

    int n_chk = 0;
    int n_err = 0;

    entry_t      mdl [16];
    logic [31:0] exp_fva [2];
    logic [1:0]  p_req;
    logic [31:0] p_va [2];
    logic [7:0]  p_tid [2];
    logic [2:0]  p_knd [2];
    logic        e_hit [2];
    logic [2:0]  e_cause [2];
    logic [31:0] e_pa [2];

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Reference: the requirements computed arithmetically. Kind bits are {sup, exec, write}.
    function automatic void model(input logic [31:0] va, input logic [7:0] tid, input logic [2:0] k,
                                  output logic h, output logic [2:0] c, output logic [31:0] pa);
        int cnt, hi, ob;
        cnt = 0; hi = 0;
        for (int e = 0; e < 16; e++) begin
            int o;
            o = 12 + 2 * ((mdl[e].size > 6) ? 6 : int'(mdl[e].size));
            if (mdl[e].valid && (mdl[e].global || mdl[e].tid == tid) &&
                ((va >> o) == ({mdl[e].vpn, 12'h000} >> o))) begin
                cnt++; hi = e;
            end
        end
        h = 1'b0; pa = 32'h0;
        if (cnt > 1) c = 3'd5;
        else if (cnt == 0) c = 3'd1;
        else begin
            h = 1'b1;
            if (mdl[hi].sup_only && !k[2]) c = 3'd4;
            else if (k[0] && !mdl[hi].wr_ok) c = 3'd2;
            else if (k[1] && !mdl[hi].ex_ok) c = 3'd3;
            else begin
                c  = 3'd0;
                ob = 12 + 2 * ((mdl[hi].size > 6) ? 6 : int'(mdl[hi].size));
                pa = (({mdl[hi].ppn, 12'h000} >> ob) << ob) | (va & ((32'h1 << ob) - 32'h1));
            end
        end
    endfunction

    task automatic prep(input logic [1:0] req, input logic [31:0] va0, input logic [7:0] t0, input logic [2:0] k0,
                        input logic [31:0] va1, input logic [7:0] t1, input logic [2:0] k1);
        p_req = req;
        p_va[0] = va0; p_tid[0] = t0; p_knd[0] = k0;
        p_va[1] = va1; p_tid[1] = t1; p_knd[1] = k1;
        for (int p = 0; p < 2; p++) model(p_va[p], p_tid[p], p_knd[p], e_hit[p], e_cause[p], e_pa[p]);
    endtask

    task automatic apply();
        lk_req = p_req;
        for (int p = 0; p < 2; p++) begin
            lk_va[p] = p_va[p]; lk_tid[p] = p_tid[p];
            lk_wr[p] = p_knd[p][0]; lk_ex[p] = p_knd[p][1]; lk_sup[p] = p_knd[p][2];
        end
    endtask

    task automatic finish(input string rq);
        lk_req = 2'b00;
        for (int p = 0; p < 2; p++) begin
            chk(rq, "valid", 32'(rs_valid[p]), 32'(p_req[p]));
            if (p_req[p]) begin
                if (e_cause[p] != 3'd0) exp_fva[p] = p_va[p];
                chk(rq, "hit", 32'(rs_hit[p]), 32'(e_hit[p]));
                chk(rq, "cause", 32'(rs_cause[p]), 32'(e_cause[p]));
                chk(rq, "pa", rs_pa[p], e_pa[p]);
            end
            chk(rq, "fault_va", rs_fault_va[p], exp_fva[p]);
        end
    endtask

    task automatic look(input logic [1:0] req, input logic [31:0] va0, input logic [7:0] t0, input logic [2:0] k0,
                        input logic [31:0] va1, input logic [7:0] t1, input logic [2:0] k1, input string rq);
        prep(req, va0, t0, k0, va1, t1, k1);
        @(negedge clk);
        apply();
        @(posedge clk);
        #1;
        finish(rq);
    endtask

    // Perm bits are {sup_only, ex_ok, wr_ok}.
    task automatic wr_drive(input int idx, input logic v, input logic g, input logic [7:0] t, input logic [2:0] sz,
                            input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] perm);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_valid = v; wr_global = g; wr_tid = t; wr_size = sz;
        wr_vpn = vpn; wr_ppn = ppn; wr_wr_ok = perm[0]; wr_ex_ok = perm[1]; wr_sup_only = perm[2];
    endtask

    task automatic commit();
        if (inv_all) begin
            for (int e = 0; e < 16; e++) mdl[e].valid = 1'b0;
        end else if (wr_en) begin
            mdl[wr_idx].valid = wr_valid; mdl[wr_idx].global = wr_global; mdl[wr_idx].tid = wr_tid;
            mdl[wr_idx].size = wr_size; mdl[wr_idx].vpn = wr_vpn; mdl[wr_idx].ppn = wr_ppn;
            mdl[wr_idx].wr_ok = wr_wr_ok; mdl[wr_idx].ex_ok = wr_ex_ok; mdl[wr_idx].sup_only = wr_sup_only;
        end
    endtask

    task automatic wr(input int idx, input logic v, input logic g, input logic [7:0] t, input logic [2:0] sz,
                      input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] perm);
        @(negedge clk);
        wr_drive(idx, v, g, t, sz, vpn, ppn, perm);
        @(posedge clk);
        commit();
        #1;
        wr_en = 1'b0;
    endtask

    task automatic inv();
        @(negedge clk);
        inv_all = 1'b1;
        @(posedge clk);
        commit();
        #1;
        inv_all = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_global = 1'b0; wr_tid = '0;
        wr_size = '0; wr_vpn = '0; wr_ppn = '0; wr_wr_ok = 1'b0; wr_ex_ok = 1'b0; wr_sup_only = 1'b0;
        inv_all = 1'b0; lk_req = '0; lk_va = '0; lk_tid = '0; lk_wr = '0; lk_ex = '0; lk_sup = '0;
        for (int e = 0; e < 16; e++) mdl[e] = '0;
        exp_fva[0] = '0; exp_fva[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // R13: reset state, and an empty table misses everywhere
        for (int p = 0; p < 2; p++) begin
            chk("R13", "valid", 32'(rs_valid[p]), 32'h0);
            chk("R13", "fault_va", rs_fault_va[p], 32'h0);
        end
        look(2'b11, 32'h0000_1000, 8'h00, 3'b000, 32'hFFFF_F000, 8'hFF, 3'b001, "R13");

        // R1 R4: every size code, probes at both page edges and just outside
        for (int sz = 0; sz < 8; sz++) begin
            int ob;
            logic [31:0] psz, al;
            ob  = 12 + 2 * ((sz > 6) ? 6 : sz);
            psz = 32'h1 << ob;
            al  = 32'h4055_5000 & ~(psz - 32'h1);
            inv();
            wr(5, 1'b1, 1'b0, 8'h11, 3'(sz), 20'h40555, 20'h9A5C3, 3'b011);
            look(2'b11, al, 8'h11, 3'b000, al + psz - 32'h1, 8'h11, 3'b001, "R1");
            look(2'b11, al + psz, 8'h11, 3'b000, al - 32'h1, 8'h11, 3'b000, "R1");
            look(2'b01, al + (psz >> 1) + 32'h123, 8'h11, 3'b010, 32'h0, 8'h00, 3'b000, "R4");
        end

        // R2: task tag sweep, then the same entry made global
        inv();
        wr(2, 1'b1, 1'b0, 8'h33, 3'd0, 20'h12345, 20'h0ABCD, 3'b011);
        for (int t = 0; t < 256; t++)
            look(2'b11, 32'h1234_5678, 8'(t), 3'b000, 32'h1234_5FFF, 8'(255 - t), 3'b001, "R2");
        wr(2, 1'b1, 1'b1, 8'h33, 3'd0, 20'h12345, 20'h0ABCD, 3'b011);
        look(2'b11, 32'h1234_5678, 8'h00, 3'b000, 32'h1234_5000, 8'hC4, 3'b000, "R2");

        // R5 R6 R7: every permission set against every access kind
        for (int perm = 0; perm < 8; perm++) begin
            wr(7, 1'b1, 1'b0, 8'h05, 3'd1, 20'h20004, 20'h3FFF0, 3'(perm));
            for (int k = 0; k < 8; k += 2)
                look(2'b11, 32'h2000_5ABC, 8'h05, 3'(k), 32'h2000_7000, 8'h05, 3'(k + 1), "R5,R6,R7");
        end

        // R8: overlapping 4 KB and 16 KB global entries
        inv();
        wr(0, 1'b1, 1'b0, 8'h09, 3'd0, 20'h00010, 20'h11111, 3'b011);
        wr(1, 1'b1, 1'b1, 8'h00, 3'd1, 20'h00010, 20'h22222, 3'b011);
        look(2'b11, 32'h0001_0044, 8'h09, 3'b000, 32'h0001_2044, 8'h09, 3'b000, "R8");
        look(2'b01, 32'h0001_0044, 8'h0A, 3'b000, 32'h0, 8'h00, 3'b000, "R8");

        // R10: lookup in the write cycle sees the old entry, the next sees the new one
        inv();
        prep(2'b01, 32'h0007_7123, 8'h01, 3'b000, 32'h0, 8'h00, 3'b000);
        @(negedge clk);
        wr_drive(4, 1'b1, 1'b0, 8'h01, 3'd0, 20'h00077, 20'h55555, 3'b011);
        apply();
        @(posedge clk);
        commit();
        #1;
        wr_en = 1'b0;
        finish("R10");
        look(2'b01, 32'h0007_7123, 8'h01, 3'b000, 32'h0, 8'h00, 3'b000, "R10");

        // R12 R11: fill all entries, both ports different kinds, then invalidations
        for (int e = 0; e < 16; e++)
            wr(e, 1'b1, 1'b0, 8'(e), 3'd0, 20'h10000 + 20'(e * 3), 20'hF0000 + 20'(e), 3'b001);
        for (int e = 0; e < 16; e++)
            look(2'b11, {20'h10000 + 20'(e * 3), 12'h0A0}, 8'(e), 3'b001,
                 {20'h10000 + 20'((15 - e) * 3), 12'hFFC}, 8'(15 - e), 3'b010, "R12");
        wr(6, 1'b0, 1'b0, 8'h06, 3'd0, 20'h10012, 20'hF0006, 3'b001);
        look(2'b11, 32'h1001_2000, 8'h06, 3'b000, 32'h1001_5000, 8'h07, 3'b000, "R11");
        @(negedge clk);
        inv_all = 1'b1;
        wr_drive(3, 1'b1, 1'b0, 8'h03, 3'd0, 20'h10009, 20'hF0003, 3'b001);
        @(posedge clk);
        commit();
        #1;
        inv_all = 1'b0; wr_en = 1'b0;
        for (int e = 0; e < 16; e += 2)
            look(2'b11, {20'h10000 + 20'(e * 3), 12'h000}, 8'(e), 3'b000,
                 {20'h10000 + 20'((e + 1) * 3), 12'h000}, 8'(e + 1), 3'b000, "R11");
        look(2'b00, 32'h0, 8'h00, 3'b000, 32'h0, 8'h00, 3'b000, "R9");

        summary();
        $finish;
    end

endmodule